// File: doc/BRIEF.md
# Row-to-row operand routing window

This block connects one row of processing elements in a reconfigurable data-path array to the row below it. Every element of the upstream row offers two 64-bit values: the result of its arithmetic unit and the value its transfer unit passes through unchanged. The pass-through lets data skip rows. Every element of the downstream row has three operand inputs. Each input draws from a narrow horizontal window of upstream columns centred on its own column, or it takes a 64-bit immediate that belongs to that element.

The select code is relative to the column, so it is not a full crossbar. Its width grows with the window half-width, not with the row width. A code that points past either edge of the array, or a code outside the defined range, drives a zero operand and raises that element's route-error flag. All operands and flags are registered.

Top module: `oprt_row_route`

## Requirements
- R1: Each select field is SEL_W = ceil(log2(2*(2*MAX_DIST+1))) bits wide. For element j and operand o (A=0, B=1, C=2) it sits at sel_i bits [(3*j+o)*SEL_W +: SEL_W], and the operand appears at opnd_o bits [(3*j+o)*DATA_W +: DATA_W]. For a code c below NUM_CAND = 2*(2*MAX_DIST+1), the source column is j + c/2 - MAX_DIST (integer division), and bit 0 of c picks the kind (0 = arithmetic result, 1 = pass-through).
- R2: A code with bit 0 clear and an in-array source column k delivers fu_res_i of column k.
- R3: A code with bit 0 set and an in-array source column k delivers tu_pass_i of column k.
- R4: The code equal to NUM_CAND delivers imm_i of the element's own column j, at bits [j*DATA_W +: DATA_W].
- R5: A code whose source column is below 0 or above NUM_COLS-1 delivers zero and sets route_err_o[j].
- R6: Codes above NUM_CAND are reserved. They deliver zero and set route_err_o[j].
- R7: Operands and flags are registered. A change at the inputs reaches the outputs at the next rising clock edge and not before it.
- R8: While rst_ni is low, all operands and all route-error flags are zero. This takes effect at once, without waiting for a clock edge.
- R9: route_err_o[j] is the OR over the three operands of element j. It is clear when none of the three has an R5 or R6 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fu_res_i | input | NUM_COLS*DATA_W | Arithmetic results of the upstream row, column 0 in the low bits |
| tu_pass_i | input | NUM_COLS*DATA_W | Pass-through values of the upstream row |
| sel_i | input | NUM_COLS*3*SEL_W | Relative select codes, three per element |
| imm_i | input | NUM_COLS*DATA_W | Immediate value of each downstream element |
| opnd_o | output | NUM_COLS*3*DATA_W | Registered operands A, B and C of each element |
| route_err_o | output | NUM_COLS | Registered route-error flag of each element |

## Verification
The assertions inside each column check every cycle that an immediate, arithmetic or pass-through selection shows up one clock later with the value its source had. They also check that a faulty selection produces a zero operand with the flag raised, and that a clean element never shows a raised flag. The bench's sweeps show what the assertions cannot. The edge columns' out-of-array codes give zero at the left and right boundaries. The bit positions of every field and operand match the packing rule. The outputs hold before the clock edge. An asynchronous reset in mid-run clears everything at once.

// File: rtl/oprt_pkg.sv
package oprt_pkg;
  localparam int OPNDS_PER_PE = 3;

  // two candidates (result, pass-through) per window column
  function automatic int cand_count(int max_dist);
    return 2 * (2 * max_dist + 1);
  endfunction

  // 4*M+2 is never a power of two for M>=1, so code cand_count always fits
  function automatic int sel_width(int max_dist);
    return $clog2(cand_count(max_dist));
  endfunction
endpackage

// File: rtl/oprt_opnd_pick.sv
module oprt_opnd_pick #(
  parameter int DATA_W   = 64,
  parameter int NUM_CAND = 6,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_CAND*DATA_W-1:0] cand_data_i,
  input  logic [NUM_CAND-1:0]        cand_ok_i,
  input  logic [DATA_W-1:0]          imm_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [DATA_W-1:0]          data_o,
  output logic                       bad_o
);
  always_comb begin
    data_o = '0;
    bad_o  = 1'b0;
    if (sel_i == SEL_W'(NUM_CAND)) begin
      data_o = imm_i;
    end else if (int'(sel_i) > NUM_CAND) begin
      bad_o = 1'b1;
    end else begin
      for (int c = 0; c < NUM_CAND; c++) begin
        if (int'(sel_i) == c) begin
          if (cand_ok_i[c]) data_o = cand_data_i[c*DATA_W +: DATA_W];
          else              bad_o  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/oprt_col.sv
module oprt_col
  import oprt_pkg::*;
#(
  parameter int MAX_DIST = 2,
  parameter int DATA_W   = 64,
  localparam int WIN      = 2 * MAX_DIST + 1,
  localparam int NUM_CAND = cand_count(MAX_DIST),
  localparam int SEL_W    = sel_width(MAX_DIST)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [WIN*DATA_W-1:0]          win_fu_i,
  input  logic [WIN*DATA_W-1:0]          win_tu_i,
  input  logic [WIN-1:0]                 win_ok_i,
  input  logic [OPNDS_PER_PE*SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0]              imm_i,
  output logic [OPNDS_PER_PE*DATA_W-1:0] opnd_o,
  output logic                           err_o
);
  logic [NUM_CAND*DATA_W-1:0]     cand_data;
  logic [NUM_CAND-1:0]            cand_ok;
  logic [OPNDS_PER_PE*DATA_W-1:0] pick_data;
  logic [OPNDS_PER_PE-1:0]        pick_bad;

  // even code: arithmetic result, odd code: pass-through
  for (genvar w = 0; w < WIN; w++) begin : g_cand
    assign cand_data[(2*w)*DATA_W   +: DATA_W] = win_fu_i[w*DATA_W +: DATA_W];
    assign cand_data[(2*w+1)*DATA_W +: DATA_W] = win_tu_i[w*DATA_W +: DATA_W];
    assign cand_ok[2*w]   = win_ok_i[w];
    assign cand_ok[2*w+1] = win_ok_i[w];
  end

  for (genvar o = 0; o < OPNDS_PER_PE; o++) begin : g_opnd
    oprt_opnd_pick #(
      .DATA_W  (DATA_W),
      .NUM_CAND(NUM_CAND),
      .SEL_W   (SEL_W)
    ) u_pick (
      .cand_data_i(cand_data),
      .cand_ok_i  (cand_ok),
      .imm_i      (imm_i),
      .sel_i      (sel_i[o*SEL_W +: SEL_W]),
      .data_o     (pick_data[o*DATA_W +: DATA_W]),
      .bad_o      (pick_bad[o])
    );

    assert_imm_pick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[o*SEL_W +: SEL_W] == SEL_W'(NUM_CAND))
      |=> (opnd_o[o*DATA_W +: DATA_W] == $past(imm_i)));

    assert_bad_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pick_bad[o] |=> (opnd_o[o*DATA_W +: DATA_W] == '0) && err_o);

    for (genvar w = 0; w < WIN; w++) begin : g_chk
      assert_fu_pick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_ok_i[w] && sel_i[o*SEL_W +: SEL_W] == SEL_W'(2*w))
        |=> (opnd_o[o*DATA_W +: DATA_W] == $past(win_fu_i[w*DATA_W +: DATA_W])));

      assert_tu_pick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_ok_i[w] && sel_i[o*SEL_W +: SEL_W] == SEL_W'(2*w+1))
        |=> (opnd_o[o*DATA_W +: DATA_W] == $past(win_tu_i[w*DATA_W +: DATA_W])));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_o <= '0;
      err_o  <= 1'b0;
    end else begin
      opnd_o <= pick_data;
      err_o  <= |pick_bad;
    end
  end

  assert_clean_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_bad == '0) |=> !err_o);
endmodule

// File: rtl/oprt_row_route.sv
module oprt_row_route
  import oprt_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int MAX_DIST = 2,   // must be at least 1
  parameter int DATA_W   = 64,
  localparam int SEL_W   = sel_width(MAX_DIST)
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [NUM_COLS*DATA_W-1:0]              fu_res_i,
  input  logic [NUM_COLS*DATA_W-1:0]              tu_pass_i,
  input  logic [NUM_COLS*OPNDS_PER_PE*SEL_W-1:0]  sel_i,
  input  logic [NUM_COLS*DATA_W-1:0]              imm_i,
  output logic [NUM_COLS*OPNDS_PER_PE*DATA_W-1:0] opnd_o,
  output logic [NUM_COLS-1:0]                     route_err_o
);
  localparam int WIN      = 2 * MAX_DIST + 1;
  localparam int PAD_COLS = NUM_COLS + 2 * MAX_DIST;

  // pad both edges so every column sees a full window; pad slots are marked invalid
  logic [PAD_COLS*DATA_W-1:0] fu_pad;
  logic [PAD_COLS*DATA_W-1:0] tu_pad;
  logic [PAD_COLS-1:0]        ok_pad;

  assign fu_pad = {{(MAX_DIST*DATA_W){1'b0}}, fu_res_i,  {(MAX_DIST*DATA_W){1'b0}}};
  assign tu_pad = {{(MAX_DIST*DATA_W){1'b0}}, tu_pass_i, {(MAX_DIST*DATA_W){1'b0}}};
  assign ok_pad = {{MAX_DIST{1'b0}}, {NUM_COLS{1'b1}}, {MAX_DIST{1'b0}}};

  for (genvar j = 0; j < NUM_COLS; j++) begin : g_col
    oprt_col #(
      .MAX_DIST(MAX_DIST),
      .DATA_W  (DATA_W)
    ) u_col (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .win_fu_i(fu_pad[j*DATA_W +: WIN*DATA_W]),
      .win_tu_i(tu_pad[j*DATA_W +: WIN*DATA_W]),
      .win_ok_i(ok_pad[j +: WIN]),
      .sel_i   (sel_i[j*OPNDS_PER_PE*SEL_W +: OPNDS_PER_PE*SEL_W]),
      .imm_i   (imm_i[j*DATA_W +: DATA_W]),
      .opnd_o  (opnd_o[j*OPNDS_PER_PE*DATA_W +: OPNDS_PER_PE*DATA_W]),
      .err_o   (route_err_o[j])
    );
  end
endmodule

// File: tb/oprt_row_route_test.sv
module oprt_row_route_test;
  localparam int N  = 4;
  localparam int M  = 1;
  localparam int W  = 64;
  localparam int SW = 3;
  localparam int NC = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N*W-1:0]    fu_bus = '0;
  logic [N*W-1:0]    tu_bus = '0;
  logic [N*3*SW-1:0] sel_bus = '0;
  logic [N*W-1:0]    imm_bus = '0;
  logic [N*3*W-1:0]  opnd;
  logic [N-1:0]      rerr;

  always #4 clk = ~clk;

  oprt_row_route #(.NUM_COLS(N), .MAX_DIST(M), .DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .fu_res_i(fu_bus), .tu_pass_i(tu_bus),
    .sel_i(sel_bus), .imm_i(imm_bus), .opnd_o(opnd), .route_err_o(rerr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [W-1:0] fu_v [N];
  logic [W-1:0] tu_v [N];
  logic [W-1:0] imm_v [N];
  int           sel_v [N][3];
  logic [W-1:0] prev_op [N][3];
  logic         prev_err [N];

  task automatic chk64(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic calc(int j, int o, output logic [W-1:0] d, output bit bad, output string tag);
    int code, col;
    code = sel_v[j][o];
    d = '0; bad = 1'b0;
    if (code == NC) begin
      d = imm_v[j]; tag = "R4";
    end else if (code > NC) begin
      bad = 1'b1; tag = "R6";
    end else begin
      col = j + code / 2 - M;
      if (col < 0 || col >= N) begin
        bad = 1'b1; tag = "R5";
      end else if (code % 2 == 1) begin
        d = tu_v[col]; tag = "R3";
      end else begin
        d = fu_v[col]; tag = "R2";
      end
    end
  endtask

  // R1: field and operand packing used to drive and to sample
  task automatic drive();
    for (int j = 0; j < N; j++) begin
      fu_bus[j*W +: W]  = fu_v[j];
      tu_bus[j*W +: W]  = tu_v[j];
      imm_bus[j*W +: W] = imm_v[j];
      for (int o = 0; o < 3; o++) sel_bus[(3*j+o)*SW +: SW] = SW'(sel_v[j][o]);
    end
  endtask

  task automatic rand_data();
    for (int j = 0; j < N; j++) begin
      fu_v[j]  = {$urandom, $urandom};
      tu_v[j]  = {$urandom, $urandom};
      imm_v[j] = {$urandom, $urandom};
    end
  endtask

  // apply at negedge, confirm hold before the edge (R7), check after it
  task automatic step();
    logic [W-1:0] d; bit bad; string tag; bit eacc;
    drive();
    #1;
    for (int j = 0; j < N; j++)
      for (int o = 0; o < 3; o++)
        chk64($sformatf("R7 hold col %0d op %0d", j, o), opnd[(3*j+o)*W +: W], prev_op[j][o]);
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      eacc = 1'b0;
      for (int o = 0; o < 3; o++) begin
        calc(j, o, d, bad, tag);
        eacc |= bad;
        chk64($sformatf("%s R1 col %0d op %0d code %0d", tag, j, o, sel_v[j][o]),
              opnd[(3*j+o)*W +: W], d);
        prev_op[j][o] = d;
      end
      chk64($sformatf("R9 flag col %0d", j), 64'(rerr[j]), 64'(eacc));
      prev_err[j] = eacc;
    end
  endtask

  initial begin
    for (int j = 0; j < N; j++) begin
      fu_v[j] = '0; tu_v[j] = '0; imm_v[j] = '0; prev_err[j] = 1'b0;
      for (int o = 0; o < 3; o++) begin sel_v[j][o] = NC; prev_op[j][o] = '0; end
    end
    drive();
    repeat (3) @(negedge clk);
    for (int i = 0; i < N*3; i++) chk64("R8 reset operand", opnd[i*W +: W], '0);
    chk64("R8 reset flags", 64'(rerr), '0);
    rst_ni = 1'b1;
    @(negedge clk);
    // exhaustive: every code on every operand of every column
    for (int j = 0; j < N; j++)
      for (int o = 0; o < 3; o++)
        for (int c = 0; c < 8; c++) begin
          for (int jj = 0; jj < N; jj++)
            for (int oo = 0; oo < 3; oo++) sel_v[jj][oo] = NC;
          sel_v[j][o] = c;
          rand_data();
          step();
        end
    // random full configurations
    for (int t = 0; t < 300; t++) begin
      for (int j = 0; j < N; j++)
        for (int o = 0; o < 3; o++) sel_v[j][o] = int'($urandom % 8);
      rand_data();
      step();
    end
    // mid-run async reset
    for (int j = 0; j < N; j++)
      for (int o = 0; o < 3; o++) sel_v[j][o] = NC;
    for (int j = 0; j < N; j++) imm_v[j] = 64'hFFFF_0000_0000_0001 + 64'(j);
    step();
    #2 rst_ni = 1'b0;
    #1;
    for (int i = 0; i < N*3; i++) chk64("R8 async clear", opnd[i*W +: W], '0);
    chk64("R8 async flags", 64'(rerr), '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule